// File: doc/BRIEF.md
# Condition Flag Generator

This block produces the next four-bit condition flag value (negative, zero, carry, overflow) of a 32-bit integer core from the result of the operation that just finished. It is purely combinational. The datapath supplies the result, the adder carry-out, the sign bits of both operands, the shifter carry-out and a two-bit operation class. The block then applies the update rule for that class. Where the rule leaves a flag untouched, it passes on the current flag value.

The adder is assumed to subtract by computing `a + ~b + 1`. Its carry-out is therefore 1 exactly when the subtraction needs no borrow, and this is the carry flag value after a subtraction. When the update enable is low, the current flags pass through unchanged. The output can feed the flag register directly.

Top module: `flag_gen`

## Requirements
- R1: When the update enable is high, N (output bit 3) equals bit 31 of the result.
- R2: When the update enable is high, Z (output bit 2) is 1 exactly when all 32 result bits are zero.
- R3: For operation class 2'b00 (add) with update enabled, C (output bit 1) equals the adder carry-out, i.e. 1 on unsigned overflow.
- R4: For operation class 2'b01 (subtract) with update enabled, C equals the adder carry-out: 0 when a borrow occurs, 1 otherwise.
- R5: For operation class 2'b10 (logical with shift) with update enabled, C equals the shifter carry-out.
- R6: For operation class 2'b11 (other logical) with update enabled, C keeps its current value.
- R7: For add with update enabled, V (output bit 0) is 1 exactly when both operand signs are equal and the result sign differs from them.
- R8: For subtract with update enabled, V is 1 exactly when the first operand sign differs from the second operand sign and the result sign differs from the first operand sign.
- R9: For operation classes 2'b10 and 2'b11 with update enabled, V keeps its current value.
- R10: When the update enable is low, all four output flags equal the current flags, whatever the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| result_i | input | 32 | Result of the completed operation |
| add_cout_i | input | 1 | Adder carry-out (no-borrow when subtracting) |
| a_sign_i | input | 1 | Sign bit of first operand |
| b_sign_i | input | 1 | Sign bit of second operand, before any inversion |
| shift_cout_i | input | 1 | Last bit shifted out by the shifter |
| op_class_i | input | 2 | 00 add, 01 subtract, 10 logical with shift, 11 other |
| upd_en_i | input | 1 | Flag update enable |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The assertions assume that the result, carry-out and operand signs come from one consistent operation. For subtract, this means a carry-out that equals no-borrow and a result equal to a minus b. The assertions never check the carry against operand values, because the block only sees sign bits. The random stimulus respects this. For add and subtract it derives the result, carry and signs from two random 32-bit operands in the bench. For the logical classes, where no such relation exists, it uses independent random results and shifter bits. Directed cases cover the signed overflow limits, a zero result with and without carry, and a disabled update with all other inputs set.

// File: rtl/flag_pkg.sv
package flag_pkg;
  parameter int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    OPC_ADD   = 2'b00,
    OPC_SUB   = 2'b01,
    OPC_SHIFT = 2'b10,
    OPC_OTHER = 2'b11
  } op_class_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/flag_nz_unit.sv
module flag_nz_unit #(
  parameter int unsigned WIDTH = flag_pkg::DATA_W
) (
  input  logic [WIDTH-1:0] result_i,
  output logic             neg_o,
  output logic             zero_o
);
  localparam int unsigned MSB = WIDTH - 1;

  assign neg_o  = result_i[MSB];
  assign zero_o = ~|result_i;
endmodule

// File: rtl/flag_carry_sel.sv
module flag_carry_sel
  import flag_pkg::*;
(
  input  op_class_e op_i,
  input  logic      add_cout_i,
  input  logic      shift_cout_i,
  input  logic      cur_c_i,
  output logic      c_o
);
  always_comb begin
    unique case (op_i)
      OPC_ADD,
      OPC_SUB:   c_o = add_cout_i;   // sub: a + ~b + 1, carry is no-borrow
      OPC_SHIFT: c_o = shift_cout_i;
      default:   c_o = cur_c_i;
    endcase
  end
endmodule

// File: rtl/flag_ovf_det.sv
module flag_ovf_det
  import flag_pkg::*;
(
  input  op_class_e op_i,
  input  logic      a_sign_i,
  input  logic      b_sign_i,
  input  logic      res_sign_i,
  input  logic      cur_v_i,
  output logic      v_o
);
  logic arith;
  logic b_eff;
  logic ovf;

  assign arith = (op_i == OPC_ADD) || (op_i == OPC_SUB);
  assign b_eff = (op_i == OPC_SUB) ? ~b_sign_i : b_sign_i;
  assign ovf   = (a_sign_i == b_eff) && (res_sign_i != a_sign_i);
  assign v_o   = arith ? ovf : cur_v_i;
endmodule

// File: rtl/flag_gen.sv
module flag_gen
  import flag_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic [WIDTH-1:0] result_i,
  input  logic             add_cout_i,
  input  logic             a_sign_i,
  input  logic             b_sign_i,
  input  logic             shift_cout_i,
  input  logic [1:0]       op_class_i,
  input  logic             upd_en_i,
  input  logic [3:0]       flags_i,
  output logic [3:0]       flags_o
);
  localparam int unsigned MSB = WIDTH - 1;

  op_class_e op;
  flags_t    cur;
  flags_t    nxt;
  flags_t    out;
  logic      neg, zero, c_new, v_new;

  assign op  = op_class_e'(op_class_i);
  assign cur = flags_t'(flags_i);

  flag_nz_unit #(.WIDTH(WIDTH)) u_nz (
    .result_i (result_i),
    .neg_o    (neg),
    .zero_o   (zero)
  );

  flag_carry_sel u_c (
    .op_i         (op),
    .add_cout_i   (add_cout_i),
    .shift_cout_i (shift_cout_i),
    .cur_c_i      (cur.c),
    .c_o          (c_new)
  );

  flag_ovf_det u_v (
    .op_i       (op),
    .a_sign_i   (a_sign_i),
    .b_sign_i   (b_sign_i),
    .res_sign_i (result_i[MSB]),
    .cur_v_i    (cur.v),
    .v_o        (v_new)
  );

  assign nxt     = '{n: neg, z: zero, c: c_new, v: v_new};
  assign out     = upd_en_i ? nxt : cur;
  assign flags_o = out;

  always_comb begin
    if (!upd_en_i) begin
      p_hold_all_r10: assert (flags_o == flags_i) else $error("R10 hold");
    end else begin
      p_neg_r1: assert (flags_o[3] == result_i[MSB]) else $error("R1 N");
      p_zero_r2: assert (flags_o[2] == (result_i == '0)) else $error("R2 Z");
      if (op_class_i == 2'b10) begin
        p_c_shift_r5: assert (flags_o[1] == shift_cout_i) else $error("R5 C");
      end
      if (op_class_i == 2'b11) begin
        p_c_keep_r6: assert (flags_o[1] == flags_i[1]) else $error("R6 C");
      end
      if (op_class_i[1]) begin
        p_v_keep_r9: assert (flags_o[0] == flags_i[0]) else $error("R9 V");
      end
      if (op_class_i == 2'b00 && flags_o[0]) begin
        p_add_ovf_r7: assert (a_sign_i == b_sign_i && result_i[MSB] != a_sign_i)
          else $error("R7 V");
      end
      if (op_class_i == 2'b01 && flags_o[0]) begin
        p_sub_ovf_r8: assert (a_sign_i != b_sign_i && result_i[MSB] != a_sign_i)
          else $error("R8 V");
      end
    end
  end
endmodule

// File: tb/tb_flag_gen.sv
module tb_flag_gen;
  logic        clk = 1'b0;
  logic [31:0] result_i = '0;
  logic        add_cout_i = 1'b0, a_sign_i = 1'b0, b_sign_i = 1'b0, shift_cout_i = 1'b0;
  logic [1:0]  op_class_i = 2'b00;
  logic        upd_en_i = 1'b0;
  logic [3:0]  flags_i = 4'h0;
  logic [3:0]  flags_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flag_gen dut (.*);

  function automatic logic [3:0] model(input logic [1:0] op, input logic en,
      input logic [31:0] r, input logic co, input logic as, input logic bs,
      input logic sc, input logic [3:0] cur);
    logic n, z, c, v, be;
    if (!en) return cur;
    n = r[31];
    z = (r == 32'd0);
    c = (op[1] == 1'b0) ? co : (op == 2'b10 ? sc : cur[1]);
    be = (op == 2'b01) ? ~bs : bs;
    v = (op[1] == 1'b0) ? ((as == be) && (r[31] != as)) : cur[0];
    return {n, z, c, v};
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%b en=%b act=%b exp=%b", tag, op_class_i, upd_en_i, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic en, input logic [31:0] r,
      input logic co, input logic as, input logic bs, input logic sc, input logic [3:0] cur);
    logic [3:0] e;
    @(posedge clk);
    op_class_i = op; upd_en_i = en; result_i = r; add_cout_i = co;
    a_sign_i = as; b_sign_i = bs; shift_cout_i = sc; flags_i = cur;
    e = model(op, en, r, co, as, bs, sc, cur);
    @(negedge clk);
    if (!en) begin
      n_chk++;
      if (flags_o !== e) begin
        n_fail++;
        $display("FAIL R10 act=%h exp=%h", flags_o, e);
      end
    end else begin
      check("R1", flags_o[3], e[3]);
      check("R2", flags_o[2], e[2]);
      case (op)
        2'b00: begin check("R3", flags_o[1], e[1]); check("R7", flags_o[0], e[0]); end
        2'b01: begin check("R4", flags_o[1], e[1]); check("R8", flags_o[0], e[0]); end
        2'b10: begin check("R5", flags_o[1], e[1]); check("R9", flags_o[0], e[0]); end
        default: begin check("R6", flags_o[1], e[1]); check("R9", flags_o[0], e[0]); end
      endcase
    end
  endtask

  task automatic arith(input logic sub, input logic [31:0] a, input logic [31:0] b,
      input logic [3:0] cur);
    logic [32:0] s;
    s = sub ? ({1'b0, a} + {1'b0, ~b} + 33'd1) : ({1'b0, a} + {1'b0, b});
    apply({1'b0, sub}, 1'b1, s[31:0], s[32], a[31], b[31], 1'b0, cur);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // reset-state / disabled pass-through (R10)
    apply(2'b00, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0101);
    apply(2'b10, 1'b0, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 4'b1010);
    // directed corners
    arith(1'b0, 32'h7FFF_FFFF, 32'h1, 4'h0);          // R7 overflow
    arith(1'b0, 32'hFFFF_FFFF, 32'h1, 4'h0);          // R3 carry, R2 zero
    arith(1'b0, 32'h8000_0000, 32'h8000_0000, 4'h0);  // R7 neg+neg
    arith(1'b1, 32'h8000_0000, 32'h1, 4'hF);          // R8 overflow
    arith(1'b1, 32'h0, 32'h0, 4'h0);                  // R4 no borrow, zero
    arith(1'b1, 32'h0, 32'h1, 4'h0);                  // R4 borrow
    arith(1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'h0);  // R8 overflow
    apply(2'b10, 1'b1, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0001); // R5, R9
    apply(2'b11, 1'b1, 32'h0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0011); // R6, R9
    apply(2'b11, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0000); // R6
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] op;
      logic [3:0] cur;
      op  = 2'($urandom);
      cur = 4'($urandom);
      if ($urandom_range(0, 7) == 0)
        apply(op, 1'b0, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), cur);
      else if (op[1] == 1'b0)
        arith(op[0], $urandom, ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom, cur);
      else
        apply(op, 1'b1, ($urandom_range(0, 5) == 0) ? 32'h0 : $urandom,
              1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), cur);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule